// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt and Wake Detection

This block is a word-addressed general-purpose I/O controller for a configurable number of pins. The pins are grouped into banks of 32. Each bank has its own copy of every register type. Software programs the pins through a simple register port: an address, a write strobe and write data, with read data returned in the same cycle. The pad side has an input, an output and an output enable for every pin.

Output levels are changed through separate write-only set and clear registers, so one pin can be updated without a read-modify-write. Every pad input is synchronized before use. A pin can then be programmed to raise an event in one of two ways:
- on its rising edge, its falling edge, or both, in edge mode;
- while it sits at a chosen level (high or low), in level mode.

Events are held in a sticky status register that is cleared by writing 1s to it. The status bits are gated by a mask and combined into a single interrupt line. A parallel wake path, with its own mask and its own sticky status, drives a separate wake output.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every readable register reads 0, and `pad_oe`, `pad_out`, `irq` and `wake` are all 0.
- R2: The pin-level register (offset 0x004 + 4·bank) is read-only. It returns each pin's input after a two-flop synchronizer. A pad change sampled at a rising edge is readable after the second rising edge counted from that edge, and writes to the register have no effect.
- R3: Writing to the set register (0x034 + 4·bank) drives `pad_out` high on every bit written as 1. Writing to the clear register (0x04C + 4·bank) drives `pad_out` low on every bit written as 1. Bits written as 0 leave their pins unchanged, and both registers read back as 0.
- R4: A bit of 1 in the direction register (0x01C + 4·bank) drives that pin's `pad_oe` high; a bit of 0 makes the pin an input. `pad_oe` changes only in the cycle after a register write.
- R5: When a pin's input-type bit (0x300 + 4·bank) is 0, the pin is in edge mode. A rising edge sets its status bit (0x0C4 + 4·bank) if its rising enable (0x064 + 4·bank) is 1, and a falling edge sets it if its falling enable (0x07C + 4·bank) is 1; both edges may be enabled at once. Edges of the other kind are ignored. The status bit reads 1 after the third rising edge counting from the edge that samples the pad change.
- R6: Writing a 1 to a status bit clears it. If an event and the clearing write fall in the same cycle, the event wins and the bit stays set.
- R7: `irq` is 1 exactly when some pin has both its status bit and its mask bit (0x0AC + 4·bank, 1 means enabled) at 1. It follows status and mask changes in the same cycle.
- R8: When a pin's input-type bit is 1, the pin is in level mode. Its status bit is set on every cycle in which the synchronized input is at the active level, so it cannot be cleared while that level holds. The polarity bit (0x318 + 4·bank) selects the active level: 1 for low, 0 for high.
- R9: The wake status bit (0x418 + 4·bank) of a pin is set by the same events as its interrupt status, but only while its wake-mask bit (0x400 + 4·bank) is 1. It is cleared by writing 1 to it. `wake` is 1 exactly when some pin has both its wake status and its wake mask at 1.
- R10: Pin p uses bit p mod 32 of the word at a register type's base offset plus 4·(p div 32). Pins 32 and up therefore sit in the following words.
- R11: Reads of the set and clear registers, and reads of any address that is not mapped, return 0. Writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 12 | Byte address of the register word |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| pad_out | output | NUM_PINS | Pad output levels |
| pad_oe | output | NUM_PINS | Pad output enables |
| irq | output | 1 | Combined masked interrupt |
| wake | output | 1 | Combined masked wake request |

## Verification
A pad change that is sampled at edge k is readable as a level after edge k+1. It reaches the edge or level status, `irq` and `wake` after edge k+2.

A register write presented before an edge takes effect at that edge. Its effect on `pad_out`, `pad_oe`, the status bits and the combined outputs is therefore visible right after that edge. Read data is combinational on the current address.

The bench drives stimulus just after a rising edge and updates its model at each rising edge from the inputs that were stable before it. It compares every output, and the read data for the current address, at the following falling edge. Directed reads of the status registers wait at least four edges after a pad change, so they fall outside the synchronizer latency.

// File: rtl/gpio_ctrl_pkg.sv
// Shared constants, types and the address decoder for the banked GPIO
// controller. Assumes 12-bit byte addresses and word-aligned accesses.
package gpio_ctrl_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int MAX_BANKS = 6;

    localparam logic [ADDR_W-1:0] OFS_LEVEL = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_SET   = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_RISE  = 12'h064;
    localparam logic [ADDR_W-1:0] OFS_FALL  = 12'h07C;
    localparam logic [ADDR_W-1:0] OFS_IMASK = 12'h0AC;
    localparam logic [ADDR_W-1:0] OFS_ISTAT = 12'h0C4;
    localparam logic [ADDR_W-1:0] OFS_ITYPE = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_LPOL  = 12'h318;
    localparam logic [ADDR_W-1:0] OFS_WMASK = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_WSTAT = 12'h418;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_DIR,
        SEL_SET,
        SEL_CLR,
        SEL_RISE,
        SEL_FALL,
        SEL_IMASK,
        SEL_ISTAT,
        SEL_ITYPE,
        SEL_LPOL,
        SEL_WMASK,
        SEL_WSTAT
    } reg_sel_e;

    // Write strobes for one bank, one per writable register type.
    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
        logic rise;
        logic fall;
        logic imask;
        logic istat;
        logic itype;
        logic lpol;
        logic wmask;
        logic wstat;
    } bank_wr_t;

    // Readable contents of one bank.
    typedef struct packed {
        logic [WORD_W-1:0] level;
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] rise;
        logic [WORD_W-1:0] fall;
        logic [WORD_W-1:0] imask;
        logic [WORD_W-1:0] istat;
        logic [WORD_W-1:0] itype;
        logic [WORD_W-1:0] lpol;
        logic [WORD_W-1:0] wmask;
        logic [WORD_W-1:0] wstat;
    } bank_view_t;

    // Which register type of the given bank the address selects, if any.
    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr, input int bank);
        logic [ADDR_W-1:0] step;
        step = ADDR_W'(bank * 4);
        if (addr == OFS_LEVEL + step) return SEL_LEVEL;
        if (addr == OFS_DIR   + step) return SEL_DIR;
        if (addr == OFS_SET   + step) return SEL_SET;
        if (addr == OFS_CLR   + step) return SEL_CLR;
        if (addr == OFS_RISE  + step) return SEL_RISE;
        if (addr == OFS_FALL  + step) return SEL_FALL;
        if (addr == OFS_IMASK + step) return SEL_IMASK;
        if (addr == OFS_ISTAT + step) return SEL_ISTAT;
        if (addr == OFS_ITYPE + step) return SEL_ITYPE;
        if (addr == OFS_LPOL  + step) return SEL_LPOL;
        if (addr == OFS_WMASK + step) return SEL_WMASK;
        if (addr == OFS_WSTAT + step) return SEL_WSTAT;
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
// Two-flop synchronizer for a vector of asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_event_detect.sv
// Per-pin event detector. Edge mode compares the synchronized input with
// its value one cycle earlier; level mode reports the active level each
// cycle. Assumes the input is already synchronized.
module gpio_event_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] level_mode,
    input  logic [W-1:0] active_low,
    output logic [W-1:0] evt
);

    logic [W-1:0] lvl_prev_q;
    logic [W-1:0] rose;
    logic [W-1:0] fell;
    logic [W-1:0] at_level;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev_q <= '0;
        else        lvl_prev_q <= lvl;
    end

    // Combine the edge and level detections per pin.
    always_comb begin
        rose     = lvl & ~lvl_prev_q & rise_en;
        fell     = ~lvl & lvl_prev_q & fall_en;
        at_level = lvl ^ active_low;
        evt      = (~level_mode & (rose | fell)) | (level_mode & at_level);
    end

endmodule

// File: rtl/gpio_bank.sv
// One 32-pin bank: configuration registers, output latch, sticky interrupt
// and wake status. Pins at or above VALID_PINS are tied off and read 0.
// Assumes write strobes are already decoded for this bank.
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int VALID_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_wr_t          wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] lvl,
    output bank_view_t        view,
    output logic [WORD_W-1:0] pin_out,
    output logic [WORD_W-1:0] pin_oe,
    output logic              irq_any,
    output logic              wake_any
);

    localparam logic [WORD_W-1:0] VMASK = (VALID_PINS >= WORD_W) ? {WORD_W{1'b1}}
                                        : ((WORD_W'(1) << VALID_PINS) - WORD_W'(1));

    logic [WORD_W-1:0] wd;
    logic [WORD_W-1:0] lvl_v;
    logic [WORD_W-1:0] dir_q, out_q, rise_q, fall_q, imask_q;
    logic [WORD_W-1:0] istat_q, itype_q, lpol_q, wmask_q, wstat_q;
    logic [WORD_W-1:0] evt;
    logic [WORD_W-1:0] istat_clr;
    logic [WORD_W-1:0] wstat_clr;

    assign wd    = wdata & VMASK;
    assign lvl_v = lvl & VMASK;

    gpio_event_detect #(.W(WORD_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl_v),
        .rise_en    (rise_q),
        .fall_en    (fall_q),
        .level_mode (itype_q),
        .active_low (lpol_q),
        .evt        (evt)
    );

    // Plain read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            rise_q  <= '0;
            fall_q  <= '0;
            imask_q <= '0;
            itype_q <= '0;
            lpol_q  <= '0;
            wmask_q <= '0;
        end else begin
            if (wr.dir)   dir_q   <= wd;
            if (wr.rise)  rise_q  <= wd;
            if (wr.fall)  fall_q  <= wd;
            if (wr.imask) imask_q <= wd;
            if (wr.itype) itype_q <= wd;
            if (wr.lpol)  lpol_q  <= wd;
            if (wr.wmask) wmask_q <= wd;
        end
    end

    // Output latch updated by set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr.set) out_q <= out_q | wd;
        else if (wr.clr) out_q <= out_q & ~wd;
    end

    // Write-1-to-clear masks for the two status registers.
    always_comb begin
        istat_clr = wr.istat ? wd : '0;
        wstat_clr = wr.wstat ? wd : '0;
    end

    // Sticky status; a new event outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            istat_q <= '0;
            wstat_q <= '0;
        end else begin
            istat_q <= (istat_q & ~istat_clr) | evt;
            wstat_q <= (wstat_q & ~wstat_clr) | (evt & wmask_q);
        end
    end

    // Collect bank outputs and readable view.
    always_comb begin
        pin_out    = out_q;
        pin_oe     = dir_q;
        irq_any    = |(istat_q & imask_q);
        wake_any   = |(wstat_q & wmask_q);
        view.level = lvl_v;
        view.dir   = dir_q;
        view.rise  = rise_q;
        view.fall  = fall_q;
        view.imask = imask_q;
        view.istat = istat_q;
        view.itype = itype_q;
        view.lpol  = lpol_q;
        view.wmask = wmask_q;
        view.wstat = wstat_q;
    end

endmodule

// File: rtl/gpio_ctrl.sv
// Banked GPIO controller top: synchronizes the pads, decodes the register
// port into per-bank strobes, muxes read data and combines interrupt and
// wake requests. Assumes NUM_PINS <= 192 so the register arrays stay apart.
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq,
    output logic                wake
);

    localparam int NB     = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int FULL_W = NB * WORD_W;

    logic [NUM_PINS-1:0] lvl_sync;
    logic [FULL_W-1:0]   lvl_full;
    logic [FULL_W-1:0]   out_full;
    logic [FULL_W-1:0]   oe_full;
    logic [FULL_W-1:0]   imask_all;
    logic [FULL_W-1:0]   wmask_all;
    logic [NB-1:0]       irq_bank;
    logic [NB-1:0]       wake_bank;
    bank_view_t          views [NB];

    gpio_sync2 #(.W(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (lvl_sync)
    );

    // Widen the synchronized pads to whole banks.
    always_comb begin
        lvl_full                = '0;
        lvl_full[NUM_PINS-1:0]  = lvl_sync;
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int BP = ((NUM_PINS - b * WORD_W) >= WORD_W) ? WORD_W : (NUM_PINS - b * WORD_W);

        reg_sel_e sel;
        bank_wr_t wr;

        // Turn the shared address into this bank's write strobes.
        always_comb begin
            sel      = decode_sel(reg_addr, b);
            wr.dir   = reg_we && (sel == SEL_DIR);
            wr.set   = reg_we && (sel == SEL_SET);
            wr.clr   = reg_we && (sel == SEL_CLR);
            wr.rise  = reg_we && (sel == SEL_RISE);
            wr.fall  = reg_we && (sel == SEL_FALL);
            wr.imask = reg_we && (sel == SEL_IMASK);
            wr.istat = reg_we && (sel == SEL_ISTAT);
            wr.itype = reg_we && (sel == SEL_ITYPE);
            wr.lpol  = reg_we && (sel == SEL_LPOL);
            wr.wmask = reg_we && (sel == SEL_WMASK);
            wr.wstat = reg_we && (sel == SEL_WSTAT);
        end

        gpio_bank #(.VALID_PINS(BP)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr),
            .wdata    (reg_wdata),
            .lvl      (lvl_full[b*WORD_W +: WORD_W]),
            .view     (views[b]),
            .pin_out  (out_full[b*WORD_W +: WORD_W]),
            .pin_oe   (oe_full[b*WORD_W +: WORD_W]),
            .irq_any  (irq_bank[b]),
            .wake_any (wake_bank[b])
        );

        assign imask_all[b*WORD_W +: WORD_W] = views[b].imask;
        assign wmask_all[b*WORD_W +: WORD_W] = views[b].wmask;
    end

    // Select the read word of whichever bank and type the address names.
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NB; b++) begin
            case (decode_sel(reg_addr, b))
                SEL_LEVEL: reg_rdata = views[b].level;
                SEL_DIR:   reg_rdata = views[b].dir;
                SEL_RISE:  reg_rdata = views[b].rise;
                SEL_FALL:  reg_rdata = views[b].fall;
                SEL_IMASK: reg_rdata = views[b].imask;
                SEL_ISTAT: reg_rdata = views[b].istat;
                SEL_ITYPE: reg_rdata = views[b].itype;
                SEL_LPOL:  reg_rdata = views[b].lpol;
                SEL_WMASK: reg_rdata = views[b].wmask;
                SEL_WSTAT: reg_rdata = views[b].wstat;
                default:   ;
            endcase
        end
    end

    // Drive the pads and the combined request lines.
    always_comb begin
        pad_out = out_full[NUM_PINS-1:0];
        pad_oe  = oe_full[NUM_PINS-1:0];
        irq     = |irq_bank;
        wake    = |wake_bank;
    end

endmodule

// File: rtl/gpio_ctrl_checker.sv
// Temporal checks on the GPIO controller, attached by bind. Assumes the
// first bank is populated; the set/clear checks look at bank 0 only.
module gpio_ctrl_checker
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_we,
    input logic [WORD_W-1:0]   reg_wdata,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic                irq,
    input logic                wake,
    input logic [((NUM_PINS + WORD_W - 1) / WORD_W) * WORD_W - 1:0] imask_all,
    input logic [((NUM_PINS + WORD_W - 1) / WORD_W) * WORD_W - 1:0] wmask_all
);

    localparam int LO = (NUM_PINS < WORD_W) ? NUM_PINS : WORD_W;

    // R3: a set write leaves every written-1 bit of bank 0 high.
    assert_set_drives_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_SET) |=>
            ((pad_out[LO-1:0] & $past(reg_wdata[LO-1:0])) == $past(reg_wdata[LO-1:0])));

    // R3: a clear write leaves every written-1 bit of bank 0 low.
    assert_clr_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == OFS_CLR) |=>
            ((pad_out[LO-1:0] & $past(reg_wdata[LO-1:0])) == '0));

    // R3: outputs only move after a register write.
    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> $stable(pad_out));

    // R4: output enables only move after a register write.
    assert_oe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> $stable(pad_oe));

    // R7: the interrupt needs at least one enabled mask bit.
    assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|imask_all));

    // R9: the wake line needs at least one wake-mask bit.
    assert_wake_needs_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (|wmask_all));

endmodule

bind gpio_ctrl gpio_ctrl_checker #(.NUM_PINS(NUM_PINS)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .wake      (wake),
    .imask_all (imask_all),
    .wmask_all (wmask_all)
);

// File: tb/gpio_ctrl_tb.sv
// Self-checking bench: behavioural model updated on each rising edge,
// compared with all outputs on each falling edge, plus directed reads.
module gpio_ctrl_tb;

    localparam int NP = 64;
    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;
    logic          irq;
    logic          wake;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_ctrl #(.NUM_PINS(NP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq),
        .wake      (wake)
    );

    // Register type index: 0 level, 1 dir, 2 set, 3 clr, 4 rise, 5 fall,
    // 6 imask, 7 istat, 8 itype, 9 lpol, 10 wmask, 11 wstat.
    localparam logic [11:0] TBASE [12] = '{12'h004, 12'h01C, 12'h034, 12'h04C,
                                           12'h064, 12'h07C, 12'h0AC, 12'h0C4,
                                           12'h300, 12'h318, 12'h400, 12'h418};

    logic [NP-1:0] m_dir, m_out, m_rise, m_fall, m_imask, m_istat;
    logic [NP-1:0] m_itype, m_lpol, m_wmask, m_wstat;
    logic [NP-1:0] hist [$];

    function automatic int find_reg(input logic [11:0] a, output int bk);
        for (int t = 0; t < 12; t++)
            for (int b = 0; b < NB; b++)
                if (a == TBASE[t] + 12'(4 * b)) begin
                    bk = b;
                    return t;
                end
        bk = 0;
        return -1;
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int bk;
        int t;
        logic [NP-1:0] src;
        t = find_reg(a, bk);
        case (t)
            0:  src = hist[1];
            1:  src = m_dir;
            4:  src = m_rise;
            5:  src = m_fall;
            6:  src = m_imask;
            7:  src = m_istat;
            8:  src = m_itype;
            9:  src = m_lpol;
            10: src = m_wmask;
            11: src = m_wstat;
            default: return 32'h0;
        endcase
        return src[32*bk +: 32];
    endfunction

    // Reference model: one step per rising edge from pre-edge inputs.
    always @(posedge clk) begin : model_step
        logic [NP-1:0] s, p, evt, wm0, w1c_i, w1c_w, wfull;
        int t, bk;
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_rise = '0; m_fall = '0; m_imask = '0;
            m_istat = '0; m_itype = '0; m_lpol = '0; m_wmask = '0; m_wstat = '0;
            hist.delete();
            repeat (3) hist.push_back('0);
        end else begin
            s     = hist[1];
            p     = hist[0];
            evt   = (~m_itype & ((s & ~p & m_rise) | (~s & p & m_fall))) | (m_itype & (s ^ m_lpol));
            wm0   = m_wmask;
            w1c_i = '0;
            w1c_w = '0;
            if (reg_we) begin
                t = find_reg(reg_addr, bk);
                wfull = '0;
                wfull[32*bk +: 32] = reg_wdata;
                case (t)
                    1:  m_dir[32*bk +: 32]   = reg_wdata;
                    2:  m_out                = m_out | wfull;
                    3:  m_out                = m_out & ~wfull;
                    4:  m_rise[32*bk +: 32]  = reg_wdata;
                    5:  m_fall[32*bk +: 32]  = reg_wdata;
                    6:  m_imask[32*bk +: 32] = reg_wdata;
                    7:  w1c_i                = wfull;
                    8:  m_itype[32*bk +: 32] = reg_wdata;
                    9:  m_lpol[32*bk +: 32]  = reg_wdata;
                    10: m_wmask[32*bk +: 32] = reg_wdata;
                    11: w1c_w                = wfull;
                    default: ;
                endcase
            end
            m_istat = (m_istat & ~w1c_i) | evt;
            m_wstat = (m_wstat & ~w1c_w) | (evt & wm0);
            hist.push_back(pad_in);
            void'(hist.pop_front());
        end
    end

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({63'b0, irq},  {63'b0, |(m_istat & m_imask)}, "R7 irq vs model");
            check({63'b0, wake}, {63'b0, |(m_wstat & m_wmask)}, "R9 wake vs model");
            check(pad_out, m_out, "R3 pad_out vs model");
            check(pad_oe,  m_dir, "R4 pad_oe vs model");
            check({32'b0, reg_rdata}, {32'b0, model_read(reg_addr)}, "R10 read data vs model");
        end
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        check({32'b0, reg_rdata}, {32'b0, exp}, tag);
    endtask

    task automatic set_pads(input logic [NP-1:0] v);
        @(posedge clk); #1;
        pad_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check_pin(input logic act, input logic exp, input string tag);
        @(negedge clk);
        check({63'b0, act}, {63'b0, exp}, tag);
    endtask

    initial begin
        logic [NP-1:0] pads;
        pads = '0;
        idle(4);
        @(posedge clk); #1 rst_n = 1'b1;

        // R1: reset state
        rd(12'h01C, 32'h0, "R1 direction after reset");
        rd(12'h0C4, 32'h0, "R1 status after reset");
        rd(12'h400, 32'h0, "R1 wake mask after reset");
        rd(12'h004, 32'h0, "R1 level after reset");
        @(negedge clk);
        check(pad_oe, 64'h0, "R1 pad_oe after reset");
        check({62'b0, irq, wake}, 64'h0, "R1 irq and wake after reset");

        // R4 and R3: direction, set and clear
        wr(12'h01C, 32'h00FF_0000);
        wr(12'h034, 32'h00A5_0000);
        wr(12'h04C, 32'h0005_0000);
        @(negedge clk);
        check({56'b0, pad_out[23:16]}, 64'hA0, "R3 set then clear");
        check({32'b0, pad_oe[31:0]}, 64'h00FF_0000, "R4 direction to pad_oe");
        wr(12'h020, 32'h0000_0008);
        wr(12'h038, 32'h0000_0008);
        check_pin(pad_out[35], 1'b1, "R10 bank 1 set drives pin 35");
        check_pin(pad_oe[35], 1'b1, "R10 bank 1 direction on pin 35");

        // R11: write-only and unmapped reads, read-only write
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h034, 32'h0, "R11 set register reads 0");
        rd(12'h04C, 32'h0, "R11 clear register reads 0");
        rd(12'h010, 32'h0, "R11 unmapped reads 0");
        rd(12'h004, 32'h0, "R2 level unaffected by write");

        // R2: synchronized level readback
        pads[63:32] = 32'hCAFE_0000;
        set_pads(pads);
        idle(3);
        rd(12'h008, 32'hCAFE_0000, "R2 level of bank 1");

        // R5: edge modes
        wr(12'h064, 32'h0000_0005);
        wr(12'h07C, 32'h0000_0006);
        wr(12'h0AC, 32'h0000_0007);
        pads[0] = 1'b1; set_pads(pads); idle(4);
        rd(12'h0C4, 32'h1, "R5 rising edge latches pin 0");
        check_pin(irq, 1'b1, "R7 irq on enabled status");
        wr(12'h0C4, 32'h1);
        rd(12'h0C4, 32'h0, "R6 write one clears pin 0");
        check_pin(irq, 1'b0, "R7 irq drops after clear");
        pads[1] = 1'b1; set_pads(pads); idle(4);
        rd(12'h0C4, 32'h0, "R5 rising ignored on falling-only pin");
        pads[1] = 1'b0; set_pads(pads); idle(4);
        rd(12'h0C4, 32'h2, "R5 falling edge latches pin 1");
        pads[2] = 1'b1; set_pads(pads); idle(4);
        rd(12'h0C4, 32'h6, "R5 both-edge pin rising");
        wr(12'h0C4, 32'h6);
        pads[2] = 1'b0; set_pads(pads); idle(4);
        rd(12'h0C4, 32'h4, "R5 both-edge pin falling");
        wr(12'h0C4, 32'h4);

        // R7: masked pin keeps irq low until unmasked
        wr(12'h064, 32'h0000_000D);
        pads[3] = 1'b1; set_pads(pads); idle(4);
        rd(12'h0C4, 32'h8, "R7 masked pin still latches");
        check_pin(irq, 1'b0, "R7 masked pin holds irq low");
        wr(12'h0AC, 32'h0000_000F);
        check_pin(irq, 1'b1, "R7 unmasking raises irq");
        wr(12'h0C4, 32'h8);

        // R8: level modes and clear while active
        wr(12'h318, 32'h0000_0020);
        wr(12'h300, 32'h0000_0030);
        wr(12'h0AC, 32'h0000_003F);
        idle(2);
        rd(12'h0C4, 32'h20, "R8 active-low pin latches while low");
        wr(12'h0C4, 32'h20);
        rd(12'h0C4, 32'h20, "R6 clear loses to active level");
        pads[5] = 1'b1; set_pads(pads); idle(4);
        wr(12'h0C4, 32'h20);
        rd(12'h0C4, 32'h0, "R8 clear succeeds once inactive");
        pads[4] = 1'b1; set_pads(pads); idle(4);
        rd(12'h0C4, 32'h10, "R8 active-high pin latches");
        pads[4] = 1'b0; set_pads(pads); idle(4);
        wr(12'h0C4, 32'h10);
        rd(12'h0C4, 32'h0, "R8 active-high clear after release");

        // R9: wake path
        wr(12'h400, 32'h0000_0001);
        pads[0] = 1'b0; set_pads(pads); idle(4);
        pads[0] = 1'b1; set_pads(pads); idle(4);
        check_pin(wake, 1'b1, "R9 wake on masked pin edge");
        rd(12'h418, 32'h1, "R9 wake status pin 0");
        wr(12'h418, 32'h1);
        rd(12'h418, 32'h0, "R9 wake status cleared");
        check_pin(wake, 1'b0, "R9 wake drops after clear");
        pads[2] = 1'b1; set_pads(pads); idle(4);
        check_pin(wake, 1'b0, "R9 unmasked pin gives no wake");
        rd(12'h418, 32'h0, "R9 wake status stays 0");

        // R10: bank 1 interrupt addressing
        wr(12'h0C4, 32'hFFFF_FFFF);
        wr(12'h068, 32'h0000_0100);
        wr(12'h0B0, 32'h0000_0100);
        pads[40] = 1'b1; set_pads(pads); idle(4);
        rd(12'h0C8, 32'h100, "R10 pin 40 status in bank 1 bit 8");
        rd(12'h0C4, 32'h0, "R10 bank 0 status unaffected");
        check_pin(irq, 1'b1, "R10 bank 1 drives irq");
        wr(12'h0C8, 32'h100);
        check_pin(irq, 1'b0, "R10 bank 1 clear drops irq");

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule